// File: doc/BRIEF.md
# Register Block-Transfer Address Sequencer

This block sequences a multi-register memory transfer. A 16-bit mask names the registers to move. On a start pulse the block captures a base byte address, the mask, a writeback enable, a direction flag (load or store) and an addressing mode. It then produces one (register index, word address) pair per accepted cycle on a valid/ready stream. When the sequence ends it pulses done and presents the base value that the register file should take. The block moves no data itself. A downstream memory and register-file stage consumes the stream.

Two addressing modes are supported. Increment-after starts at the base and steps upward by one 4-byte word per register. Decrement-before places the whole block below the base, so registers still land at ascending addresses. This gives the save and restore behaviour of a descending stack. When a load includes register 15, a flag tells the pipeline that the program counter was reloaded, for example on a return.

The stream follows plain valid/ready rules. An item is consumed in a cycle where valid and ready are both high at the clock edge. While valid is high and ready is low, the register index and address stay unchanged, and the block waits for as long as ready stays low. Ready may toggle freely. Valid never depends on ready.

Top module: `lsm_addr_seq`

## Requirements
- R1: Registers whose mask bit is set are emitted in strictly ascending index order. Mask bit i names register i.
- R2: With mode_i = 0 (increment-after), the first emitted address is the base and each following address is 4 higher.
- R3: With mode_i = 1 (decrement-before), the first emitted address is base minus 4 times the number of set mask bits. Each following address is 4 higher.
- R4: With wb_en_i = 1, wb_base_o during done equals base + 4·n in mode 0 and base − 4·n in mode 1, where n is the number of set mask bits. With wb_en_i = 0 it equals the original base.
- R5: While xfer_valid_o is high and xfer_ready_i is low, xfer_reg_o and xfer_addr_o hold their values. Exactly one item is consumed per cycle with both high.
- R6: done_o is high for exactly one cycle. That cycle is the one after the last accepted item. busy_o is high from the cycle after an accepted start through the done cycle.
- R7: An all-zero mask produces no stream items. done_o rises in the cycle right after the start, and wb_base_o equals the original base.
- R8: start_i is ignored while busy_o is high. The running sequence keeps its registers and addresses.
- R9: pc_loaded_o is high in the done cycle only when load_i = 1 (load direction) and mask bit 15 was set. It is low for stores and for loads without bit 15.
- R10: After reset busy_o, xfer_valid_o, done_o and pc_loaded_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a sequence (taken only when idle) |
| base_i | input | 32 | Base byte address |
| mask_i | input | 16 | Register selection mask |
| wb_en_i | input | 1 | Report an updated base when set |
| load_i | input | 1 | 1 = load direction, 0 = store |
| mode_i | input | 1 | 0 = increment-after, 1 = decrement-before |
| busy_o | output | 1 | Sequence in progress |
| xfer_valid_o | output | 1 | Stream item present |
| xfer_ready_i | input | 1 | Consumer accepts the item |
| xfer_reg_o | output | 4 | Register index of the item |
| xfer_addr_o | output | 32 | Word address of the item |
| done_o | output | 1 | One-cycle completion pulse |
| wb_base_o | output | 32 | Base value to write back, valid with done_o |
| pc_loaded_o | output | 1 | Program counter reloaded, valid with done_o |

## Verification
The bench drives sparse masks, a full mask, single-bit masks at both ends and an empty mask, in both modes and under random back-pressure. A scanner that walks from the top bit would emit registers in descending order. Addresses that advance on stalled cycles would skip words. In decrement-before mode, a base taken as the first address or written back as base + 4n would show up as address and writeback mismatches. A restart accepted mid-sequence, an empty mask that hangs or emits a stray item, and a program-counter flag raised on a store would each break a scoreboard or done-cycle check.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  localparam int WORD_BYTES = 4;
  localparam int WORD_SHIFT = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } lsm_state_e;

  typedef enum logic {
    MODE_INC_AFTER  = 1'b0,
    MODE_DEC_BEFORE = 1'b1
  } lsm_mode_e;
endpackage

// File: rtl/lsm_popcount.sv
module lsm_popcount #(
  parameter int N  = 16,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < N; i++) begin
      cnt_o = cnt_o + CW'(vec_i[i]);
    end
  end
endmodule

// File: rtl/lsm_lowest.sv
module lsm_lowest #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic [N-1:0]  onehot_o,
  output logic [IW-1:0] idx_o
);
  assign onehot_o = vec_i & (~vec_i + N'(1));

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot_o[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/lsm_addr_plan.sv
module lsm_addr_plan #(
  parameter int AW = 32,
  parameter int CW = 5
) (
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] count_i,
  input  logic          mode_i,
  input  logic          wb_en_i,
  output logic [AW-1:0] first_o,
  output logic [AW-1:0] wb_o
);
  import lsm_pkg::*;

  logic [AW-1:0] span;
  logic [AW-1:0] low_addr;
  logic [AW-1:0] high_addr;
  logic [AW-1:0] final_base;

  assign span       = AW'(count_i) << WORD_SHIFT;
  assign low_addr   = base_i - span;
  assign high_addr  = base_i + span;
  assign first_o    = (mode_i == MODE_DEC_BEFORE) ? low_addr : base_i;
  assign final_base = (mode_i == MODE_DEC_BEFORE) ? low_addr : high_addr;
  assign wb_o       = wb_en_i ? final_base : base_i;
endmodule

// File: rtl/lsm_addr_seq.sv
module lsm_addr_seq #(
  parameter int AW   = 32,
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG),
  localparam int CW  = $clog2(NREG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] base_i,
  input  logic [NREG-1:0] mask_i,
  input  logic          wb_en_i,
  input  logic          load_i,
  input  logic          mode_i,
  output logic          busy_o,
  output logic          xfer_valid_o,
  input  logic          xfer_ready_i,
  output logic [IW-1:0] xfer_reg_o,
  output logic [AW-1:0] xfer_addr_o,
  output logic          done_o,
  output logic [AW-1:0] wb_base_o,
  output logic          pc_loaded_o
);
  import lsm_pkg::*;

  lsm_state_e      state_q;
  logic [NREG-1:0] rem_q;
  logic [AW-1:0]   addr_q;
  logic [AW-1:0]   wb_q;
  logic            pc_q;

  logic [CW-1:0]   start_cnt;
  logic [AW-1:0]   start_first;
  logic [AW-1:0]   start_wb;
  logic [NREG-1:0] low_onehot;
  logic [IW-1:0]   low_idx;
  logic [NREG-1:0] rem_next;
  logic            accept_start;
  logic            fire;

  lsm_popcount #(.N(NREG), .CW(CW)) u_count (
    .vec_i (mask_i),
    .cnt_o (start_cnt)
  );

  lsm_addr_plan #(.AW(AW), .CW(CW)) u_plan (
    .base_i  (base_i),
    .count_i (start_cnt),
    .mode_i  (mode_i),
    .wb_en_i (wb_en_i),
    .first_o (start_first),
    .wb_o    (start_wb)
  );

  lsm_lowest #(.N(NREG), .IW(IW)) u_pick (
    .vec_i    (rem_q),
    .onehot_o (low_onehot),
    .idx_o    (low_idx)
  );

  assign accept_start = (state_q == ST_IDLE) && start_i;
  assign fire         = xfer_valid_o && xfer_ready_i;
  assign rem_next     = rem_q & ~low_onehot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      addr_q  <= '0;
      wb_q    <= '0;
      pc_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept_start) begin
            rem_q   <= mask_i;
            addr_q  <= start_first;
            wb_q    <= start_wb;
            pc_q    <= load_i && mask_i[NREG-1];
            state_q <= (mask_i == '0) ? ST_FIN : ST_RUN;
          end
        end
        ST_RUN: begin
          if (fire) begin
            rem_q  <= rem_next;
            addr_q <= addr_q + AW'(WORD_BYTES);
            if (rem_next == '0) state_q <= ST_FIN;
          end
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign xfer_valid_o = (state_q == ST_RUN);
  assign xfer_reg_o   = low_idx;
  assign xfer_addr_o  = addr_q;
  assign done_o       = (state_q == ST_FIN);
  assign wb_base_o    = wb_q;
  assign pc_loaded_o  = done_o && pc_q;

  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (!xfer_valid_o || (xfer_reg_o > $past(xfer_reg_o)))); // R1

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (!xfer_valid_o || (xfer_addr_o == $past(xfer_addr_o) + AW'(WORD_BYTES)))); // R2

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid_o && !xfer_ready_i) |=>
      (xfer_valid_o && $stable(xfer_reg_o) && $stable(xfer_addr_o))); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6

  AST_EMPTY_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && (mask_i == '0)) |=> (done_o && !xfer_valid_o)); // R7

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid_o && !xfer_ready_i && start_i) |=> $stable(xfer_addr_o)); // R8

  AST_PC_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    pc_loaded_o |-> done_o); // R9
endmodule

// File: tb/lsm_addr_seq_tb.sv
module lsm_addr_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [15:0] mask_i = '0;
  logic        wb_en_i = 1'b0;
  logic        load_i = 1'b0;
  logic        mode_i = 1'b0;
  logic        busy_o, xfer_valid_o, done_o, pc_loaded_o;
  logic        xfer_ready_i = 1'b0;
  logic [3:0]  xfer_reg_o;
  logic [31:0] xfer_addr_o, wb_base_o;

  int checks = 0;
  int failures = 0;
  logic [35:0] exp_q[$];
  bit stall_mode = 0;
  bit hold_ready = 0;
  logic [15:0] lfsr = 16'hACE1;

  lsm_addr_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
    .mask_i(mask_i), .wb_en_i(wb_en_i), .load_i(load_i), .mode_i(mode_i),
    .busy_o(busy_o), .xfer_valid_o(xfer_valid_o), .xfer_ready_i(xfer_ready_i),
    .xfer_reg_o(xfer_reg_o), .xfer_addr_o(xfer_addr_o), .done_o(done_o),
    .wb_base_o(wb_base_o), .pc_loaded_o(pc_loaded_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ready generator: changes just after the rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (hold_ready) xfer_ready_i = 1'b0;
      else if (stall_mode) xfer_ready_i = lfsr[0];
      else xfer_ready_i = 1'b1;
    end
  end

  // monitor: pops the scoreboard on every accepted item (R1 R2 R3 R5)
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && xfer_valid_o && xfer_ready_i) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R1 unexpected item", {xfer_reg_o, xfer_addr_o}, '0);
        end else begin
          logic [35:0] e;
          e = exp_q.pop_front();
          check({xfer_reg_o, xfer_addr_o} == e, "R1/R2/R3 item", {xfer_reg_o, xfer_addr_o}, e);
        end
      end
    end
  end

  task automatic run_seq(input logic [31:0] base, input logic [15:0] mask,
                         input bit wb, input bit ld, input bit mode, input bit probe);
    int n = 0;
    logic [31:0] a;
    logic [31:0] exp_wb;
    int waited = 0;
    for (int i = 0; i < 16; i++) n += int'(mask[i]);
    a = mode ? base - 32'(4 * n) : base;
    for (int i = 0; i < 16; i++) begin
      if (mask[i]) begin
        exp_q.push_back({4'(i), a});
        a = a + 32'd4;
      end
    end
    exp_wb = !wb ? base : (mode ? base - 32'(4 * n) : base + 32'(4 * n));
    if (probe) hold_ready = 1;
    @(posedge clk); #2;
    base_i = base; mask_i = mask; wb_en_i = wb; load_i = ld; mode_i = mode; start_i = 1'b1;
    @(posedge clk); #2;
    start_i = 1'b0;
    if (mask == 16'h0) begin
      @(negedge clk);
      check(done_o == 1'b1, "R7 done right after start", done_o, 1);
      check(!xfer_valid_o, "R7 no item", xfer_valid_o, 0);
    end else begin
      @(negedge clk);
      check(busy_o == 1'b1, "R6 busy after start", busy_o, 1);
      if (probe) begin
        // R8: restart with other values while stalled
        @(posedge clk); #2;
        base_i = 32'hDEAD0000; mask_i = 16'h7FFF; mode_i = ~mode; start_i = 1'b1;
        @(posedge clk); #2;
        start_i = 1'b0;
        @(negedge clk);
        check(xfer_reg_o == exp_q[0][35:32], "R8 reg kept", xfer_reg_o, exp_q[0][35:32]);
        check(xfer_addr_o == exp_q[0][31:0], "R8 addr kept", xfer_addr_o, exp_q[0][31:0]);
        hold_ready = 0;
      end
      while (!done_o && waited < 2000) begin
        @(negedge clk);
        waited++;
      end
    end
    check(done_o == 1'b1, "R6 done seen", done_o, 1);
    check(exp_q.size() == 0, "R6 all items before done", exp_q.size(), 0);
    check(wb_base_o == exp_wb, "R4 writeback base", wb_base_o, exp_wb);
    check(pc_loaded_o == (ld && mask[15]), "R9 pc flag", pc_loaded_o, ld && mask[15]);
    @(negedge clk);
    check(!done_o, "R6 done one cycle", done_o, 0);
    check(!busy_o, "R6 idle after done", busy_o, 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!busy_o && !xfer_valid_o && !done_o && !pc_loaded_o, "R10 reset state",
          {busy_o, xfer_valid_o, done_o, pc_loaded_o}, 0);
    rst_n = 1'b1;
    run_seq(32'h0000_1000, 16'h00C3, 1, 1, 0, 0);   // R2 R4 sparse, increment
    run_seq(32'h0000_2000, 16'h8421, 1, 1, 1, 0);   // R3 R9 decrement, pc load
    stall_mode = 1;
    run_seq(32'h0000_0100, 16'hFFFF, 1, 0, 0, 0);   // R5 full mask, store
    run_seq(32'h0000_3000, 16'h8000, 1, 0, 1, 0);   // R9 store with bit 15
    run_seq(32'h0000_4000, 16'h0001, 0, 1, 1, 0);   // R4 no writeback
    run_seq(32'h0000_5000, 16'h0000, 1, 1, 0, 0);   // R7 empty
    run_seq(32'h0000_6000, 16'h0A50, 1, 1, 1, 1);   // R8 restart probe
    stall_mode = 0;
    run_seq(32'h0000_7000, 16'h7FFE, 1, 1, 0, 0);   // R1 R9 load w/o bit 15
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule